// File: doc/BRIEF.md
# Processor Tick Timer

A tick timer that sits next to a small CPU core. It holds two 32-bit registers. One is a count register. The other is a mode word that packs a period, an interrupt enable, an interrupt pending flag and a two-bit operating mode. Each cycle in which the tick-enable input is high and the timer is running, the count rises by one.

The timer compares the low 28 bits of the incremented count with the period. When they are equal, the selected mode decides what happens to the count:
- auto-restart clears it to zero;
- one-shot freezes it;
- continuous leaves it free-running.

If the enable bit is set, the same match also latches the pending flag and raises the interrupt line. Software reads and writes both registers through a single-cycle register port.

The tick prescaler and the CPU exception logic lie outside this block.

Top module: `tick_timer`

## Requirements
- R1: After reset, the count register and the mode word both read 0x00000000, and irq_o is low.
- R2: In each cycle where tick_i is high, no count write occurs, the mode is not 0 and the one-shot stop is not in force, the count rises by exactly one. When tick_i is low, the count holds.
- R3: With mode 0 (disabled, bits 31:30 = 0), the count never changes except by a software write, and no match occurs.
- R4: A match occurs on a counting cycle when bits 27:0 of the incremented count equal the period field (bits 27:0 of the mode word). Bits 31:28 of the count play no part. If the field is already at or past the period, the next match comes only after the field wraps through zero.
- R5: In mode 1 (auto-restart), a match loads the count with zero, and counting resumes from zero.
- R6: In mode 2 (one-shot), a match leaves the count at the matched value and stops counting. Counting resumes only after software writes the mode word.
- R7: In mode 3 (continuous), a match does not disturb the count. The count keeps rising and wraps past its 32-bit maximum.
- R8: A match with the enable bit (bit 29) set sets the pending bit (bit 28). irq_o is high exactly when both pending and enable are set. A match with enable clear leaves pending unchanged.
- R9: A mode-word write loads the pending bit from bit 28 of the data, so writing 0 clears it. A match in the same cycle still sets pending.
- R10: A count write (reg_sel_i = 0) takes priority over the increment in the same cycle. The count takes the written value, and that cycle produces no match.
- R11: reg_rdata_o returns the count when reg_sel_i = 0 and the mode word when reg_sel_i = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Tick enable from the prescaler |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 = count, 1 = mode word |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| irq_o | output | 1 | Timer interrupt |

## Verification
The bench starts the count at 0x0FFFFFFE with a period of 1, a field that is past the period. This catches two kinds of fault:
- A design that compares the full 32-bit count would never match.
- A design that triggers on "field at or above the period" would fire at once.

The one-shot test keeps ticking long after the match and then rewrites the mode word. A design that fails to stop would drift past the period, and one that fails to restart would stay frozen. A count write on a ticking cycle exposes a design that lets the increment win. Clearing pending while auto-restart keeps running exposes a design whose restart also resets the count in the wrong cycle or loses the resumed count.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned PERIOD_W = 28;
  localparam int unsigned DATA_W   = PERIOD_W + 4;

  typedef enum logic [1:0] {
    TM_OFF     = 2'd0,
    TM_RESTART = 2'd1,
    TM_ONESHOT = 2'd2,
    TM_CONT    = 2'd3
  } tt_mode_e;
endpackage

// File: rtl/tt_counter.sv
module tt_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              run_i,
  input  logic              restart_i,
  output logic [DATA_W-1:0] count_o,
  output logic [DATA_W-1:0] count_inc_o
);
  logic [DATA_W-1:0] count_q;

  assign count_inc_o = count_q + DATA_W'(1);
  assign count_o     = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        count_q <= '0;
    else if (we_i)      count_q <= wdata_i;   // write wins over increment
    else if (restart_i) count_q <= '0;
    else if (run_i)     count_q <= count_inc_o;
  end

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !run_i) |=> $stable(count_q));
  p_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i && !we_i) |=> (count_q == '0));
  p_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (count_q == $past(wdata_i)));
endmodule

// File: rtl/tt_match.sv
module tt_match #(
  parameter int unsigned PERIOD_W = 28,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                run_i,
  input  logic [DATA_W-1:0]   count_inc_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                hit_o
);
  // only the low field takes part; upper count bits are free
  assign hit_o = run_i && (count_inc_i[PERIOD_W-1:0] == period_i);
endmodule

// File: rtl/tt_ctrl.sv
module tt_ctrl
  import tick_timer_pkg::*;
#(
  parameter int unsigned PERIOD_W = 28,
  localparam int unsigned DATA_W  = PERIOD_W + 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                hit_i,
  output tt_mode_e            mode_o,
  output logic [PERIOD_W-1:0] period_o,
  output logic                stopped_o,
  output logic [DATA_W-1:0]   mode_word_o,
  output logic                irq_o
);
  localparam int unsigned IP_BIT = PERIOD_W;
  localparam int unsigned IE_BIT = PERIOD_W + 1;
  localparam int unsigned MD_LSB = PERIOD_W + 2;

  tt_mode_e            mode_q;
  logic [PERIOD_W-1:0] period_q;
  logic                ie_q, ip_q, stopped_q;
  logic                ip_d, stopped_d;

  always_comb begin
    ip_d = we_i ? wdata_i[IP_BIT] : ip_q;
    if (hit_i && ie_q) ip_d = 1'b1;   // a match is never lost to a write
    stopped_d = stopped_q;
    if (hit_i && mode_q == TM_ONESHOT) stopped_d = 1'b1;
    if (we_i) stopped_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= TM_OFF;
      period_q  <= '0;
      ie_q      <= 1'b0;
      ip_q      <= 1'b0;
      stopped_q <= 1'b0;
    end else begin
      ip_q      <= ip_d;
      stopped_q <= stopped_d;
      if (we_i) begin
        mode_q   <= tt_mode_e'(wdata_i[MD_LSB +: 2]);
        period_q <= wdata_i[PERIOD_W-1:0];
        ie_q     <= wdata_i[IE_BIT];
      end
    end
  end

  assign mode_o      = mode_q;
  assign period_o    = period_q;
  assign stopped_o   = stopped_q;
  assign mode_word_o = {mode_q, ie_q, ip_q, period_q};
  assign irq_o       = ip_q & ie_q;

  p_pend_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && ie_q) |=> ip_q);
  p_pend_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_i && !we_i) |=> $stable(ip_q));
  p_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && mode_q == TM_ONESHOT && !we_i) |=> stopped_q);
  p_resume_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> !stopped_q);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        reg_we_i,
  input  logic        reg_sel_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_o
);
  logic                cnt_we, mode_we, run, hit, restart, stopped;
  logic [DATA_W-1:0]   count, count_inc, mode_word;
  logic [PERIOD_W-1:0] period;
  tt_mode_e            mode;

  assign cnt_we  = reg_we_i && !reg_sel_i;
  assign mode_we = reg_we_i &&  reg_sel_i;
  assign run     = tick_i && (mode != TM_OFF) && !stopped && !cnt_we;
  assign restart = hit && (mode == TM_RESTART);

  tt_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk_i, .rst_ni,
    .we_i(cnt_we), .wdata_i(reg_wdata_i),
    .run_i(run), .restart_i(restart),
    .count_o(count), .count_inc_o(count_inc)
  );

  tt_match #(.PERIOD_W(PERIOD_W), .DATA_W(DATA_W)) u_match (
    .run_i(run), .count_inc_i(count_inc), .period_i(period), .hit_o(hit)
  );

  tt_ctrl #(.PERIOD_W(PERIOD_W)) u_ctrl (
    .clk_i, .rst_ni,
    .we_i(mode_we), .wdata_i(reg_wdata_i), .hit_i(hit),
    .mode_o(mode), .period_o(period), .stopped_o(stopped),
    .mode_word_o(mode_word), .irq_o(irq_o)
  );

  assign reg_rdata_o = reg_sel_i ? mode_word : count;

  p_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == TM_OFF && !cnt_we) |=> $stable(count));
  p_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stopped && !reg_we_i) |=> $stable(count));
  p_no_hit_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == TM_OFF) |-> !hit);
  p_cont_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && mode == TM_CONT && !cnt_we) |=> (count[PERIOD_W-1:0] == $past(period)));
endmodule

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        we = 1'b0;
  logic        sel = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] mw(input int m, input bit ie, input bit ip,
                                     input logic [27:0] per);
    return {m[1:0], ie, ip, per};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input bit s, output logic [31:0] v);
    sel = s; #1; v = rdata;
  endtask

  task automatic wr(input bit s, input logic [31:0] d);
    we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(0, v); chk("R1 count", v, 32'h0);
    rd(1, v); chk("R1 mode", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_off;
    logic [31:0] v;
    wr(1, mw(0, 1, 0, 28'd3));
    ticks(10);
    rd(0, v); chk("R3 count frozen", v, 32'h0);
    chk("R3 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_restart;
    logic [31:0] v;
    wr(0, 32'h0);
    wr(1, mw(1, 1, 0, 28'd5));
    ticks(4);
    rd(0, v); chk("R2 count 4", v, 32'd4);
    chk("R8 irq before match", {31'b0, irq}, 32'h0);
    repeat (3) @(negedge clk);
    rd(0, v); chk("R2 hold tick low", v, 32'd4);
    ticks(1);
    rd(0, v); chk("R5 restart to zero", v, 32'h0);
    chk("R8 irq on match", {31'b0, irq}, 32'h1);
    rd(1, v); chk("R11 mode word pending", v, mw(1, 1, 1, 28'd5));
    wr(1, mw(1, 1, 0, 28'd5));
    chk("R9 pending cleared", {31'b0, irq}, 32'h0);
    ticks(2);
    rd(0, v); chk("R5 resumes from zero", v, 32'd2);
  endtask

  task automatic t_oneshot;
    logic [31:0] v;
    wr(0, 32'h0);
    wr(1, mw(2, 0, 0, 28'd3));
    ticks(10);
    rd(0, v); chk("R6 stopped at period", v, 32'd3);
    rd(1, v); chk("R8 no pending when disabled", v, mw(2, 0, 0, 28'd3));
    chk("R8 irq low", {31'b0, irq}, 32'h0);
    wr(1, mw(2, 0, 0, 28'd3));
    ticks(2);
    rd(0, v); chk("R6 resumes after mode write", v, 32'd5);
  endtask

  task automatic t_cont;
    logic [31:0] v;
    wr(0, 32'h0);
    wr(1, mw(3, 1, 0, 28'd4));
    ticks(6);
    rd(0, v); chk("R7 keeps counting", v, 32'd6);
    chk("R8 irq continuous", {31'b0, irq}, 32'h1);
    wr(0, 32'hFFFF_FFFF);
    ticks(1);
    rd(0, v); chk("R7 wraps 32 bit", v, 32'h0);
  endtask

  task automatic t_field;
    logic [31:0] v;
    wr(0, 32'h0FFF_FFFE);
    wr(1, mw(3, 1, 0, 28'd1));
    ticks(2);
    rd(0, v); chk("R4 field wrap count", v, 32'h1000_0000);
    chk("R4 no early match", {31'b0, irq}, 32'h0);
    ticks(1);
    rd(0, v); chk("R4 count at match", v, 32'h1000_0001);
    chk("R4 match on low field", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_prio;
    logic [31:0] v;
    wr(1, mw(3, 1, 0, 28'd100));
    wr(0, 32'd50);
    tick = 1'b1;
    wr(0, 32'd99);
    tick = 1'b0;
    rd(0, v); chk("R10 write beats increment", v, 32'd99);
    chk("R10 no match on write", {31'b0, irq}, 32'h0);
    ticks(1);
    chk("R10 match after write", {31'b0, irq}, 32'h1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_off();
    t_restart();
    t_oneshot();
    t_cont();
    t_field();
    t_prio();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule